// File: doc/BRIEF.md
# CEC Frame Transmitter

This block sends one message on a single-wire, open-drain CEC bus. The host fills a 16-entry byte buffer, sets a length, and writes a 2-bit command. The transmitter then waits until the line has been free for a programmable time. It sends a start bit and, for each byte, eight data bits most significant first. Each byte is followed by an end-of-message bit and an acknowledge slot. In the acknowledge slot the transmitter drives a logic 1 and reads the line back.

The result is reported as a 2-bit status code with a level interrupt. The status can show that the message completed, that a follower refused a byte, or that arbitration was lost. Arbitration is lost when another initiator holds the line low while this one has released it. All waveform timing is set by parameters counted in clock ticks. The three signal-free waits are registers, counted in units of `FREE_UNIT` ticks.

Top module: `cec_frame_tx`

## Requirements
- R1: Byte registers at addresses 0x00 to 0x0F hold the message, header at 0x00. Address 0x10 bits 3:0 hold the byte count minus one. A frame sends exactly that many bytes, in address order, each most significant bit first.
- R2: A frame opens with a start bit: the line is driven low for `START_LOW` ticks, and the first data bit begins `START_TOTAL` ticks after the start bit began.
- R3: Each bit lasts `BIT_TOTAL` ticks. A 1 is driven low for `ONE_LOW` ticks and a 0 for `ZERO_LOW` ticks. After each byte come an end-of-message bit (1 only on the final byte) and an acknowledge slot, which is driven as a 1.
- R4: The status encodings are 0 idle, 1 busy, 2 sent, 3 error. Writing command 1 to address 0x11 while no frame is in progress sets status 1. A frame whose every byte is acknowledged ends in status 2 with `txIrq` high.
- R5: For a header whose low nibble is not 0xF, an acknowledge slot read high at the sample point is a refusal. It gives status 3 and `txIrq`, and no further byte is sent.
- R6: For a header whose low nibble is 0xF (broadcast), the acknowledge sense is inverted. A slot read low is a refusal (status 3), and a slot read high passes.
- R7: If the line reads low at `SAMPLE_AT` ticks into a data or end-of-message bit that is a 1, arbitration is lost. The line is released at once, the status stays 1, and `txIrq` rises.
- R8: The start bit begins only after the line has read high continuously for the selected wait value times `FREE_UNIT` ticks. Any low reading restarts this count.
- R9: The wait registers are written as a low byte and a high byte carrying bits 10:8. Retry is at 0x12/0x13, new initiator at 0x14/0x15, and next transfer at 0x16/0x17. Command 3 uses the next-transfer wait. Command 1 uses the retry wait right after a lost arbitration, and the new-initiator wait otherwise.
- R10: Command 0 moves status 2 or 3 to 0. While a frame is in progress it has no effect.
- R11: Command 2 stops the frame at once. The line is released and the status goes to 0, and no further pulse is sent.
- R12: Any write to the command address clears `txIrq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address |
| regWdata | input | 8 | Register write data |
| cecIn | input | 1 | Sensed bus level (1 = high) |
| cecDriveLow | output | 1 | 1 pulls the open-drain bus low |
| txStatus | output | 2 | Status code (idle/busy/sent/error) |
| txIrq | output | 1 | Completion interrupt, cleared by a command write |

## Verification
The bench builds the block with a 38-tick start bit, a 20-tick bit period, 4 and 12 tick low times, a sample point at tick 9 and a free-wait unit of 2 ticks. With these values a whole multi-byte frame takes a few hundred cycles. Every pulse width can then be scored, and the follower acknowledge, a competing initiator and a held-low bus can be timed by the bench against the real sample point. The small free-wait unit keeps each of the three waits short enough that the start delay can be measured to within a few cycles. This separates the retry, new-initiator and next-transfer selections.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;

  typedef enum logic [1:0] {
    TX_ST_IDLE = 2'd0,
    TX_ST_BUSY = 2'd1,
    TX_ST_DONE = 2'd2,
    TX_ST_ERR  = 2'd3
  } txStat_e;

  typedef enum logic [1:0] {
    CMD_NOP       = 2'd0,
    CMD_SEND      = 2'd1,
    CMD_ABORT     = 2'd2,
    CMD_SEND_NEXT = 2'd3
  } txCmd_e;

  typedef enum logic [1:0] {
    WAIT_RETRY   = 2'd0,
    WAIT_NEWINIT = 2'd1,
    WAIT_NEXT    = 2'd2
  } waitSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tmrClr;
    logic tmrRun;
    logic frameClr;
    logic bitAdv;
    logic freeClr;
    logic freeRun;
  } txCtl_s;

  // observations from datapath to control
  typedef struct packed {
    logic lineLow;
    logic freeMet;
    logic startLowPh;
    logic startEnd;
    logic bitLowPh;
    logic atSample;
    logic bitEnd;
    logic curBit;
    logic isAck;
    logic lastByte;
    logic bcast;
  } txObs_s;

  localparam logic [7:0] ADDR_LEN       = 8'h10;
  localparam logic [7:0] ADDR_CMD       = 8'h11;
  localparam logic [7:0] ADDR_WAIT_BASE = 8'h12;

endpackage

// File: rtl/cec_tx_datapath.sv
module cec_tx_datapath
  import cec_tx_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int FT_W        = 11,
  parameter int START_LOW   = 370,
  parameter int START_TOTAL = 450,
  parameter int ONE_LOW     = 60,
  parameter int ZERO_LOW    = 150,
  parameter int BIT_TOTAL   = 240,
  parameter int SAMPLE_AT   = 105,
  parameter int FREE_UNIT   = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWdata,
  input  logic       cecIn,
  input  txCtl_s     ctl,
  input  waitSel_e   waitSel,
  output txObs_s     obs
);
  localparam int AW    = $clog2(DEPTH);
  localparam int MAXT  = (START_TOTAL > BIT_TOTAL) ? START_TOTAL : BIT_TOTAL;
  localparam int TW    = $clog2(MAXT + 1);
  localparam int UW    = (FREE_UNIT > 1) ? $clog2(FREE_UNIT) : 1;
  localparam int HW    = FT_W - 8;
  localparam int NWAIT = 3;

  localparam logic [TW-1:0] T_START_LOW = TW'(START_LOW);
  localparam logic [TW-1:0] T_START_END = TW'(START_TOTAL - 1);
  localparam logic [TW-1:0] T_ONE_LOW   = TW'(ONE_LOW);
  localparam logic [TW-1:0] T_ZERO_LOW  = TW'(ZERO_LOW);
  localparam logic [TW-1:0] T_BIT_END   = TW'(BIT_TOTAL - 1);
  localparam logic [TW-1:0] T_SAMPLE    = TW'(SAMPLE_AT);
  localparam logic [UW-1:0] U_LAST      = UW'(FREE_UNIT - 1);
  localparam logic [3:0]    EOM_IDX     = 4'd8;
  localparam logic [3:0]    ACK_IDX     = 4'd9;

  // bus level synchroniser
  logic [1:0] lineSync;
  logic       lineLow;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lineSync <= 2'b11;
    else       lineSync <= {lineSync[0], cecIn};
  end
  assign lineLow = ~lineSync[1];

  // message buffer and length
  logic [7:0]    msgBuf [DEPTH];
  logic [AW-1:0] lenM1;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) msgBuf[i] <= '0;
      lenM1 <= '0;
    end else if (regWe) begin
      for (int i = 0; i < DEPTH; i++)
        if (regAddr == 8'(i)) msgBuf[i] <= regWdata;
      if (regAddr == ADDR_LEN) lenM1 <= regWdata[AW-1:0];
    end
  end

  // three signal-free wait registers, low byte and high part
  generate
    for (genvar gi = 0; gi < NWAIT; gi++) begin : g_wait
      logic [FT_W-1:0] val;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) val <= '0;
        else if (regWe && regAddr == 8'(ADDR_WAIT_BASE + 2*gi))
          val[7:0] <= regWdata;
        else if (regWe && regAddr == 8'(ADDR_WAIT_BASE + 2*gi + 1))
          val[FT_W-1:8] <= regWdata[HW-1:0];
      end
    end
  endgenerate

  logic [FT_W-1:0] selWait;
  always_comb begin
    case (waitSel)
      WAIT_RETRY:   selWait = g_wait[0].val;
      WAIT_NEWINIT: selWait = g_wait[1].val;
      default:      selWait = g_wait[2].val;
    endcase
  end

  // bit timer and frame position
  logic [TW-1:0] tmr;
  logic [3:0]    bitIdx;
  logic [AW-1:0] byteIdx;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr     <= '0;
      bitIdx  <= '0;
      byteIdx <= '0;
    end else begin
      if (ctl.tmrClr)      tmr <= '0;
      else if (ctl.tmrRun) tmr <= tmr + 1'b1;
      if (ctl.frameClr) begin
        bitIdx  <= '0;
        byteIdx <= '0;
      end else if (ctl.bitAdv) begin
        if (bitIdx == ACK_IDX) begin
          bitIdx  <= '0;
          byteIdx <= byteIdx + 1'b1;
        end else begin
          bitIdx <= bitIdx + 1'b1;
        end
      end
    end
  end

  logic [7:0] curByte;
  logic       lastByte;
  logic       curBit;
  assign curByte  = msgBuf[byteIdx];
  assign lastByte = (byteIdx == lenM1);
  always_comb begin
    if (bitIdx < EOM_IDX)       curBit = curByte[3'd7 - bitIdx[2:0]];
    else if (bitIdx == EOM_IDX) curBit = lastByte;
    else                        curBit = 1'b1;
  end

  // signal-free counter
  logic [UW-1:0]   unitCnt;
  logic [FT_W-1:0] freeCnt;
  logic            freeMet;
  assign freeMet = (freeCnt >= selWait);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unitCnt <= '0;
      freeCnt <= '0;
    end else if (ctl.freeClr || (ctl.freeRun && lineLow)) begin
      unitCnt <= '0;
      freeCnt <= '0;
    end else if (ctl.freeRun) begin
      if (unitCnt == U_LAST) begin
        unitCnt <= '0;
        if (!freeMet) freeCnt <= freeCnt + 1'b1;
      end else begin
        unitCnt <= unitCnt + 1'b1;
      end
    end
  end

  assign obs.lineLow    = lineLow;
  assign obs.freeMet    = freeMet;
  assign obs.startLowPh = (tmr < T_START_LOW);
  assign obs.startEnd   = (tmr == T_START_END);
  assign obs.bitLowPh   = (tmr < (curBit ? T_ONE_LOW : T_ZERO_LOW));
  assign obs.atSample   = (tmr == T_SAMPLE);
  assign obs.bitEnd     = (tmr == T_BIT_END);
  assign obs.curBit     = curBit;
  assign obs.isAck      = (bitIdx == ACK_IDX);
  assign obs.lastByte   = lastByte;
  assign obs.bcast      = (msgBuf[0][3:0] == 4'hF);

  // frame may only open once the free wait is met on a high line
  p_start_after_free_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.frameClr |-> (obs.freeMet && !obs.lineLow));

endmodule

// File: rtl/cec_tx_control.sv
module cec_tx_control
  import cec_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWe,
  input  logic [1:0] cmdVal,
  input  txObs_s     obs,
  output txCtl_s     ctl,
  output waitSel_e   waitSel,
  output txStat_e    status,
  output logic       irq,
  output logic       driveLow
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_START, S_BITS} state_e;

  state_e   state, nState;
  txStat_e  statusQ, nStatus;
  waitSel_e selQ, nSel;
  logic     irqQ, nIrq, lostQ, nLost, ackLowQ, nAck, driveQ, nDrive;
  logic     lostNow, ackOk;

  assign lostNow = obs.atSample && obs.curBit && !obs.isAck && obs.lineLow;
  assign ackOk   = obs.bcast ^ ackLowQ;

  always_comb begin
    ctl     = '0;
    nState  = state;
    nStatus = statusQ;
    nSel    = selQ;
    nIrq    = irqQ;
    nLost   = lostQ;
    nAck    = ackLowQ;
    nDrive  = 1'b0;
    case (state)
      S_WAIT: begin
        ctl.freeRun = 1'b1;
        if (obs.freeMet && !obs.lineLow) begin
          ctl.tmrClr   = 1'b1;
          ctl.frameClr = 1'b1;
          nState       = S_START;
        end
      end
      S_START: begin
        ctl.tmrRun = 1'b1;
        nDrive     = obs.startLowPh;
        if (obs.startEnd) begin
          ctl.tmrClr = 1'b1;
          nState     = S_BITS;
        end
      end
      S_BITS: begin
        ctl.tmrRun = 1'b1;
        nDrive     = obs.bitLowPh;
        if (obs.atSample && obs.isAck) nAck = obs.lineLow;
        if (lostNow) begin
          nState = S_IDLE;
          nLost  = 1'b1;
          nIrq   = 1'b1;
          nDrive = 1'b0;
        end else if (obs.bitEnd) begin
          ctl.tmrClr = 1'b1;
          if (obs.isAck && !ackOk) begin
            nStatus = TX_ST_ERR;
            nIrq    = 1'b1;
            nState  = S_IDLE;
          end else if (obs.isAck && obs.lastByte) begin
            nStatus = TX_ST_DONE;
            nIrq    = 1'b1;
            nState  = S_IDLE;
          end else begin
            ctl.bitAdv = 1'b1;
          end
        end
      end
      default: ;
    endcase

    if (cmdWe) begin
      nIrq = 1'b0;
      case (txCmd_e'(cmdVal))
        CMD_NOP: begin
          if (statusQ == TX_ST_DONE || statusQ == TX_ST_ERR) nStatus = TX_ST_IDLE;
        end
        CMD_ABORT: begin
          ctl     = '0;
          nState  = S_IDLE;
          nStatus = TX_ST_IDLE;
          nDrive  = 1'b0;
        end
        default: begin
          if (state == S_IDLE) begin
            nState      = S_WAIT;
            nStatus     = TX_ST_BUSY;
            ctl.freeClr = 1'b1;
            nLost       = 1'b0;
            if (txCmd_e'(cmdVal) == CMD_SEND_NEXT) nSel = WAIT_NEXT;
            else if (lostQ)                        nSel = WAIT_RETRY;
            else                                   nSel = WAIT_NEWINIT;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      statusQ <= TX_ST_IDLE;
      selQ    <= WAIT_NEWINIT;
      irqQ    <= 1'b0;
      lostQ   <= 1'b0;
      ackLowQ <= 1'b0;
      driveQ  <= 1'b0;
    end else begin
      state   <= nState;
      statusQ <= nStatus;
      selQ    <= nSel;
      irqQ    <= nIrq;
      lostQ   <= nLost;
      ackLowQ <= nAck;
      driveQ  <= nDrive;
    end
  end

  assign waitSel  = selQ;
  assign status   = statusQ;
  assign irq      = irqQ;
  assign driveLow = driveQ;

  p_busy_when_active_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> (statusQ == TX_ST_BUSY));

  p_done_on_last_r1: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ == TX_ST_DONE && $past(statusQ) == TX_ST_BUSY) |-> $past(obs.lastByte));

  p_nack_error_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BITS && obs.bitEnd && obs.isAck && !obs.bcast && !ackLowQ && !cmdWe)
      |=> (statusQ == TX_ST_ERR && irqQ));

  p_lost_stays_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BITS && lostNow && !cmdWe) |=> (statusQ == TX_ST_BUSY && irqQ));

  p_nop_to_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWe && cmdVal == 2'd0 && (statusQ == TX_ST_DONE || statusQ == TX_ST_ERR))
      |=> (statusQ == TX_ST_IDLE));

  p_abort_release_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWe && cmdVal == 2'd2) |=> ##1 (!driveQ && statusQ == TX_ST_IDLE));

  p_irq_clear_r12: assert property (@(posedge clk) disable iff (!rstN)
    cmdWe |=> !irqQ);

endmodule

// File: rtl/cec_frame_tx.sv
module cec_frame_tx
  import cec_tx_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int FT_W        = 11,
  parameter int START_LOW   = 370,
  parameter int START_TOTAL = 450,
  parameter int ONE_LOW     = 60,
  parameter int ZERO_LOW    = 150,
  parameter int BIT_TOTAL   = 240,
  parameter int SAMPLE_AT   = 105,
  parameter int FREE_UNIT   = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWdata,
  input  logic       cecIn,
  output logic       cecDriveLow,
  output logic [1:0] txStatus,
  output logic       txIrq
);
  txCtl_s   ctl;
  txObs_s   obs;
  waitSel_e waitSel;
  txStat_e  status;
  logic     cmdWe;

  assign cmdWe = regWe && (regAddr == ADDR_CMD);

  cec_tx_datapath #(
    .DEPTH(DEPTH), .FT_W(FT_W), .START_LOW(START_LOW), .START_TOTAL(START_TOTAL),
    .ONE_LOW(ONE_LOW), .ZERO_LOW(ZERO_LOW), .BIT_TOTAL(BIT_TOTAL),
    .SAMPLE_AT(SAMPLE_AT), .FREE_UNIT(FREE_UNIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .cecIn(cecIn), .ctl(ctl), .waitSel(waitSel), .obs(obs)
  );

  cec_tx_control u_ctl (
    .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdVal(regWdata[1:0]), .obs(obs),
    .ctl(ctl), .waitSel(waitSel), .status(status), .irq(txIrq), .driveLow(cecDriveLow)
  );

  assign txStatus = status;

endmodule

// File: tb/cec_frame_tx_tb.sv
module cec_frame_tx_tb;
  localparam int SL = 30, ST = 38, OL = 4, ZL = 12, BT = 20, SA = 9, FU = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [7:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic       cecIn;
  logic       cecDriveLow;
  logic [1:0] txStatus;
  logic       txIrq;
  logic       followLow = 1'b0;
  logic       holdLow = 1'b0;

  always #10 clk = ~clk;
  assign cecIn = ~(cecDriveLow | followLow | holdLow);

  cec_frame_tx #(.START_LOW(SL), .START_TOTAL(ST), .ONE_LOW(OL), .ZERO_LOW(ZL),
                 .BIT_TOTAL(BT), .SAMPLE_AT(SA), .FREE_UNIT(FU)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .cecIn(cecIn), .cecDriveLow(cecDriveLow), .txStatus(txStatus), .txIrq(txIrq));

  int nChecks = 0, nFail = 0;
  int expQ[$];
  string tagQ[$];
  logic [7:0] msg [16];
  int riseCnt = 0, arbRise = 0, width = 0, follow = 0;
  bit ackEn = 0;
  logic prevDrive = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic loadMsg(input int n);
    for (int i = 0; i < n; i++) regWrite(8'(i), msg[i]);
    regWrite(8'h10, 8'(n - 1));
  endtask

  task automatic pushW(input int w, input string tag);
    expQ.push_back(w); tagQ.push_back(tag);
  endtask

  // driver side of the scoreboard: expected pulse widths
  task automatic expectFrame(input int n, input int sent);
    pushW(SL, "R2 start bit");
    for (int b = 0; b < sent; b++) begin
      for (int k = 0; k < 8; k++) pushW(msg[b][7-k] ? OL : ZL, "R1/R3 data bit");
      pushW((b == n - 1) ? OL : ZL, "R3 end-of-message bit");
      pushW(OL, "R3 ack slot");
    end
  endtask

  task automatic waitEnd();
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (txStatus != 2'd1) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic measureGap(output int g);
    g = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      g++;
      if (cecDriveLow) break;
    end
  endtask

  // monitor: measures pulses, plays follower and competitor
  always @(negedge clk) begin
    if (rstN) begin
      if (cecDriveLow && !prevDrive) begin
        riseCnt = riseCnt + 1;
        width = 1;
        if (ackEn && riseCnt >= 2 && ((riseCnt - 2) % 10) == 9) follow = 14;
        if (arbRise != 0 && riseCnt == arbRise) follow = 14;
      end else if (cecDriveLow) begin
        width = width + 1;
      end
      if (!cecDriveLow && prevDrive) begin
        if (expQ.size() == 0) check(0, "R3 unexpected pulse", width, 0);
        else begin
          automatic int e = expQ.pop_front();
          automatic string t = tagQ.pop_front();
          check(width == e, t, width, e);
        end
      end
      if (follow > 0) begin followLow = 1'b1; follow = follow - 1; end
      else followLow = 1'b0;
      prevDrive = cecDriveLow;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    int g;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txStatus == 2'd0, "R4 reset status idle", txStatus, 0);
    check(txIrq == 1'b0, "R12 reset irq low", txIrq, 0);
    check(cecDriveLow == 1'b0, "R11 reset line released", cecDriveLow, 0);

    // waits: retry 30, new initiator 0, next 15 (units)
    regWrite(8'h12, 8'd30); regWrite(8'h13, 8'd0);
    regWrite(8'h14, 8'd0);  regWrite(8'h15, 8'd0);
    regWrite(8'h16, 8'd15); regWrite(8'h17, 8'd0);

    // directed two-byte frame, acknowledged
    msg[0] = 8'h40; msg[1] = 8'hA5;
    loadMsg(2); ackEn = 1; riseCnt = 0; arbRise = 0;
    expectFrame(2, 2);
    regWrite(8'h11, 8'd1);
    check(txStatus == 2'd1, "R4 busy after send", txStatus, 1);
    repeat (100) @(negedge clk);
    regWrite(8'h11, 8'd0);
    check(txStatus == 2'd1, "R10 nop while busy ignored", txStatus, 1);
    waitEnd();
    check(txStatus == 2'd2, "R4 sent status", txStatus, 2);
    check(txIrq == 1'b1, "R4 irq on completion", txIrq, 1);
    check(expQ.size() == 0, "R1 all bytes sent", expQ.size(), 0);
    regWrite(8'h11, 8'd0);
    check(txStatus == 2'd0, "R10 nop returns idle", txStatus, 0);
    check(txIrq == 1'b0, "R12 irq cleared by command", txIrq, 0);

    // directed frame refused on first byte
    msg[0] = 8'h41; msg[1] = 8'h11; msg[2] = 8'h22;
    loadMsg(3); ackEn = 0; riseCnt = 0;
    expectFrame(3, 1);
    regWrite(8'h11, 8'd1);
    waitEnd();
    check(txStatus == 2'd3, "R5 refusal gives error", txStatus, 3);
    check(txIrq == 1'b1, "R5 irq on error", txIrq, 1);
    check(riseCnt == 11, "R5 no byte after refusal", riseCnt, 11);
    regWrite(8'h11, 8'd0);
    check(txStatus == 2'd0, "R10 nop clears error", txStatus, 0);

    // broadcast with no follower pull: passes
    msg[0] = 8'h4F; msg[1] = 8'h36;
    loadMsg(2); ackEn = 0; riseCnt = 0;
    expectFrame(2, 2);
    regWrite(8'h11, 8'd1);
    waitEnd();
    check(txStatus == 2'd2, "R6 broadcast high ack passes", txStatus, 2);
    regWrite(8'h11, 8'd0);

    // broadcast with a follower pulling low: refused
    ackEn = 1; riseCnt = 0;
    expectFrame(2, 1);
    regWrite(8'h11, 8'd1);
    waitEnd();
    check(txStatus == 2'd3, "R6 broadcast low ack refused", txStatus, 3);
    regWrite(8'h11, 8'd0);

    // lost arbitration on header bit 3 (a 1)
    msg[0] = 8'h10;
    loadMsg(1); ackEn = 1; riseCnt = 0; arbRise = 5;
    pushW(SL, "R2 start bit");
    pushW(ZL, "R7 bit0"); pushW(ZL, "R7 bit1"); pushW(ZL, "R7 bit2"); pushW(OL, "R7 bit3");
    regWrite(8'h11, 8'd1);
    repeat (400) @(negedge clk);
    check(txStatus == 2'd1, "R7 status stays busy", txStatus, 1);
    check(txIrq == 1'b1, "R7 irq on lost arbitration", txIrq, 1);
    check(riseCnt == 5, "R7 line released after loss", riseCnt, 5);
    check(expQ.size() == 0, "R7 pulses up to loss", expQ.size(), 0);

    // retry uses the retry wait
    arbRise = 0; riseCnt = 0;
    expectFrame(1, 1);
    regWrite(8'h11, 8'd1);
    check(txIrq == 1'b0, "R12 irq cleared by send", txIrq, 1'b0);
    measureGap(g);
    check(g >= 30*FU && g <= 30*FU + 6, "R9 retry wait", g, 30*FU + 2);
    waitEnd();
    check(txStatus == 2'd2, "R9 retry completes", txStatus, 2);
    regWrite(8'h11, 8'd0);

    // send-next uses the next-transfer wait
    riseCnt = 0;
    expectFrame(1, 1);
    regWrite(8'h11, 8'd3);
    measureGap(g);
    check(g >= 15*FU && g <= 15*FU + 6, "R9 next-transfer wait", g, 15*FU + 2);
    waitEnd();
    check(txStatus == 2'd2, "R9 send-next completes", txStatus, 2);
    regWrite(8'h11, 8'd0);

    // new-initiator wait of 10 with the line held low first
    regWrite(8'h14, 8'd10);
    riseCnt = 0; holdLow = 1'b1;
    expectFrame(1, 1);
    regWrite(8'h11, 8'd1);
    repeat (60) @(negedge clk);
    check(riseCnt == 0, "R8 no start while line low", riseCnt, 0);
    holdLow = 1'b0;
    measureGap(g);
    check(g >= 10*FU && g <= 10*FU + 8, "R8 free time after release", g, 10*FU + 4);
    waitEnd();
    check(txStatus == 2'd2, "R8 frame completes", txStatus, 2);
    regWrite(8'h11, 8'd0);

    // abort between pulses
    msg[0] = 8'h40; msg[1] = 8'h55; msg[2] = 8'h66;
    loadMsg(3); regWrite(8'h14, 8'd0); riseCnt = 0; ackEn = 1;
    pushW(SL, "R2 start bit"); pushW(ZL, "R11 bit0"); pushW(OL, "R11 bit1"); pushW(ZL, "R11 bit2");
    regWrite(8'h11, 8'd1);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (riseCnt == 4 && !cecDriveLow && !prevDrive) break;
    end
    regWrite(8'h11, 8'd2);
    @(negedge clk);
    check(cecDriveLow == 1'b0, "R11 line released on abort", cecDriveLow, 0);
    check(txStatus == 2'd0, "R11 idle after abort", txStatus, 0);
    repeat (300) @(negedge clk);
    check(riseCnt == 4, "R11 no pulse after abort", riseCnt, 4);
    check(expQ.size() == 0, "R11 pulses before abort", expQ.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule